// File: doc/BRIEF.md
# USB Host OUT Transaction Sequencer

This block runs the host side of one transmit endpoint in a USB controller, for bulk and interrupt OUT transfers. Software counts packets into the endpoint FIFO with a load strobe, then sets the packet-ready bit in the endpoint's control/status word. The block then asks the packet engine for an OUT token followed by a data packet, using the current data toggle as the DATA0/DATA1 choice, and waits for the handshake.

An ACK completes the transaction. A STALL halts the endpoint. A NAK makes the block try again. For bulk endpoints a budget counted in start-of-frame strobes limits the NAK retries. For interrupt endpoints a NAK defers the next attempt to the next frame. When no handshake arrives in time the attempt is repeated, up to a fixed count, before an error is reported. Every completion or fault raises a one-cycle endpoint interrupt.

After a fault, software works through the same control/status word. It clears the fault flags by writing 0 to them. It flushes queued packets. It loads or clears the toggle, or forces the toggle to flip on every attempt.

Top module: `usb_host_out_seq`

## Requirements
- R1: A control/status write with bit 0 set, while bits 2, 5 and 7 are all clear, starts a transaction. `tok_req` is high for exactly one cycle per attempt, and `tok_data1` equals the toggle (read bit 8) during that cycle.
- R2: A handshake code 0 (ACK) clears bit 0, removes one packet from the FIFO count, flips the toggle and pulses `irq` for one cycle.
- R3: A handshake code 2 (STALL) sets bit 5 and pulses `irq`. No token is issued while bit 5, bit 2 or bit 7 is set.
- R4: On a bulk endpoint (protocol code other than 2'b11), handshake code 1 (NAK) causes an immediate new attempt. SOF strobes seen while the transaction is active are counted. A NAK that arrives when the count is at least 2^(m-1), where m is `cfg_interval` (2 to 16, larger values treated as 16), sets bit 7, pulses `irq` and stops retrying.
- R5: With `cfg_interval` equal to 0 or 1, a bulk endpoint retries after NAK without limit and never sets bit 7.
- R6: An attempt with no handshake within RESP_CYCLES cycles after the token is repeated. The third consecutive silent attempt sets bit 2 and pulses `irq`. Any handshake resets the silent-attempt count.
- R7: On an interrupt endpoint (`cfg_proto` = 2'b11), a NAK holds the next attempt until the next SOF strobe, and bit 7 is never set.
- R8: Bits 2, 5 and 7 are cleared by writing 0 to them; writing 1 leaves them unchanged. Clearing bit 7 while bit 0 is still set resumes retrying with a fresh frame budget. Flushing first and then clearing bit 7 ends the transaction without another token.
- R9: `fifo_load` adds one packet to the count, up to PKT_SLOTS. Read bit 1 is 1 when the count is nonzero. Writing 1 to bit 3 removes one packet and clears bit 0.
- R10: Writing 1 to bit 6 sets the toggle to 0. Otherwise, writing 1 to bit 9 loads the toggle from write bit 8.
- R11: While bit 11 (written and read back) is set, the toggle flips after every finished attempt (ACK, NAK, STALL or silence) instead of only on ACK.
- R12: After reset the read word is 0, and `tok_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Control/status write strobe |
| csr_wdata | input | 12 | Control/status write value |
| csr_rdata | output | 12 | Control/status read value |
| cfg_proto | input | 2 | Transfer type: 2'b11 interrupt, otherwise bulk |
| cfg_interval | input | 8 | NAK budget exponent (bulk) or polling interval (interrupt) |
| fifo_load | input | 1 | One packet written into the endpoint FIFO |
| sof | input | 1 | Start-of-frame strobe |
| tok_req | output | 1 | Request for an OUT token plus data packet |
| tok_data1 | output | 1 | Data PID select: 1 = DATA1 |
| hs_valid | input | 1 | Handshake received |
| hs_code | input | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL, 3 ignored |
| irq | output | 1 | One-cycle endpoint interrupt |

## Verification
The bench builds the block with RESP_CYCLES = 6, PKT_SLOTS = 2 and MISS_LIMIT = 3. The short response window lets the three-attempt error path finish in a few dozen cycles. The two-slot FIFO makes count saturation and the double flush easy to observe. With an SOF strobe every ten cycles, an interval of 3 gives a four-frame NAK budget that runs out within about forty cycles, so the timeout, the resume after it and the abort all fit in one short run.

// File: rtl/usb_out_pkg.sv
package usb_out_pkg;

    localparam int FRAME_W = 16;

    // control/status bit positions
    localparam int B_RDY    = 0;
    localparam int B_NEMPTY = 1;
    localparam int B_ERR    = 2;
    localparam int B_FLUSH  = 3;
    localparam int B_STALL  = 5;
    localparam int B_CLRTOG = 6;
    localparam int B_NAKTO  = 7;
    localparam int B_TOG    = 8;
    localparam int B_TOGWE  = 9;
    localparam int B_FORCE  = 11;
    localparam int CSR_W    = 12;

    localparam logic [1:0] PROTO_INTR = 2'b11;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_RSVD  = 2'd3
    } hs_code_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_POLL
    } seq_state_e;

    typedef struct packed {
        logic ack;
        logic stall;
        logic nak_to;
        logic err;
        logic done;
    } seq_ev_t;

    function automatic logic limit_enabled(input logic [7:0] m);
        return m >= 8'd2;
    endfunction

    function automatic logic [FRAME_W-1:0] nak_limit(input logic [7:0] m);
        logic [7:0] e;
        e = (m > 8'd16) ? 8'd15 : (m - 8'd1);
        return FRAME_W'(1) << e;
    endfunction

endpackage

// File: rtl/usb_out_budget.sv
module usb_out_budget
    import usb_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sof_i,
    input  logic       active_i,
    input  logic       clr_i,
    input  logic [7:0] interval_i,
    output logic       limit_hit_o
);
    logic [FRAME_W-1:0] fcnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            fcnt_q <= '0;
        else if (sof_i && active_i && fcnt_q != '1)
            fcnt_q <= fcnt_q + 1'b1;
    end

    assign limit_hit_o = limit_enabled(interval_i) && (fcnt_q >= nak_limit(interval_i));

    // R4
    frame_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fcnt_q != $past(fcnt_q)) |-> (fcnt_q == '0 || fcnt_q == $past(fcnt_q) + 1'b1));

endmodule

// File: rtl/usb_out_seq.sv
module usb_out_seq
    import usb_out_pkg::*;
#(
    parameter int RESP_CYCLES = 16,
    parameter int MISS_LIMIT  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  logic       is_intr_i,
    input  logic       sof_i,
    input  logic       hs_valid_i,
    input  logic [1:0] hs_code_i,
    input  logic       limit_hit_i,
    output logic       tok_req_o,
    output logic       busy_o,
    output logic       fc_clr_o,
    output seq_ev_t    ev_o
);
    localparam int TW = $clog2(RESP_CYCLES + 1);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [TW-1:0] TMR_LAST  = TW'(RESP_CYCLES - 1);
    localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);

    seq_state_e state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic [MW-1:0] miss_q, miss_d;

    always_comb begin
        state_d  = state_q;
        tmr_d    = tmr_q;
        miss_d   = miss_q;
        fc_clr_o = 1'b0;
        ev_o     = '0;
        unique case (state_q)
            SQ_IDLE: begin
                if (go_i) begin
                    state_d  = SQ_ISSUE;
                    fc_clr_o = 1'b1;
                    miss_d   = '0;
                end
            end
            SQ_ISSUE: begin
                state_d = SQ_WAIT;
                tmr_d   = '0;
            end
            SQ_WAIT: begin
                if (hs_valid_i && hs_code_i != HS_RSVD) begin
                    ev_o.done = 1'b1;
                    miss_d    = '0;
                    case (hs_code_e'(hs_code_i))
                        HS_ACK: begin
                            ev_o.ack = 1'b1;
                            fc_clr_o = 1'b1;
                            state_d  = SQ_IDLE;
                        end
                        HS_STALL: begin
                            ev_o.stall = 1'b1;
                            state_d    = SQ_IDLE;
                        end
                        default: begin
                            if (!is_intr_i && limit_hit_i) begin
                                ev_o.nak_to = 1'b1;
                                state_d     = SQ_IDLE;
                            end else if (is_intr_i) begin
                                state_d = SQ_POLL;
                            end else begin
                                state_d = SQ_ISSUE;
                            end
                        end
                    endcase
                end else if (tmr_q == TMR_LAST) begin
                    ev_o.done = 1'b1;
                    if (miss_q == MISS_LAST) begin
                        ev_o.err = 1'b1;
                        state_d  = SQ_IDLE;
                    end else begin
                        miss_d  = miss_q + 1'b1;
                        state_d = SQ_ISSUE;
                    end
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            SQ_POLL: begin
                if (sof_i) state_d = SQ_ISSUE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            tmr_q   <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            miss_q  <= miss_d;
        end
    end

    assign tok_req_o = (state_q == SQ_ISSUE);
    assign busy_o    = (state_q != SQ_IDLE);

    // R1
    tok_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tok_req_o |=> !tok_req_o);

    // R7
    intr_no_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        is_intr_i |-> !ev_o.nak_to);

    // R3
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_o.ack, ev_o.stall, ev_o.nak_to, ev_o.err}));

endmodule

// File: rtl/usb_out_csr.sv
module usb_out_csr
    import usb_out_pkg::*;
#(
    parameter int PKT_SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [CSR_W-1:0] wdata_i,
    input  logic             fifo_load_i,
    input  seq_ev_t          ev_i,
    output logic [CSR_W-1:0] rdata_o,
    output logic             rdy_o,
    output logic             halted_o,
    output logic             tog_o,
    output logic             irq_o
);
    localparam int CW = $clog2(PKT_SLOTS + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(PKT_SLOTS);

    logic rdy_q, err_q, stall_q, nakto_q, tog_q, force_q;
    logic [CW-1:0] cnt_q;
    logic set_rdy, flush, dec, unused_wbits;

    assign set_rdy      = wr_i && wdata_i[B_RDY];
    assign flush        = wr_i && wdata_i[B_FLUSH];
    assign dec          = ev_i.ack || flush;
    assign unused_wbits = ^{wdata_i[B_NEMPTY], wdata_i[4], wdata_i[10]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q   <= 1'b0;
            err_q   <= 1'b0;
            stall_q <= 1'b0;
            nakto_q <= 1'b0;
            tog_q   <= 1'b0;
            force_q <= 1'b0;
            cnt_q   <= '0;
            irq_o   <= 1'b0;
        end else begin
            rdy_q   <= (rdy_q && !ev_i.ack && !flush) || set_rdy;
            err_q   <= (err_q   && !(wr_i && !wdata_i[B_ERR]))   || ev_i.err;
            stall_q <= (stall_q && !(wr_i && !wdata_i[B_STALL])) || ev_i.stall;
            nakto_q <= (nakto_q && !(wr_i && !wdata_i[B_NAKTO])) || ev_i.nak_to;
            if (wr_i) force_q <= wdata_i[B_FORCE];
            if (wr_i && wdata_i[B_CLRTOG])
                tog_q <= 1'b0;
            else if (wr_i && wdata_i[B_TOGWE])
                tog_q <= wdata_i[B_TOG];
            else if (force_q ? ev_i.done : ev_i.ack)
                tog_q <= !tog_q;
            if (fifo_load_i && !dec && cnt_q < CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
            else if (dec && !fifo_load_i && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            irq_o <= ev_i.ack || ev_i.stall || ev_i.err || ev_i.nak_to;
        end
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[B_RDY]    = rdy_q;
        rdata_o[B_NEMPTY] = (cnt_q != '0);
        rdata_o[B_ERR]    = err_q;
        rdata_o[B_STALL]  = stall_q;
        rdata_o[B_NAKTO]  = nakto_q;
        rdata_o[B_TOG]    = tog_q;
        rdata_o[B_FORCE]  = force_q;
    end

    assign rdy_o    = rdy_q;
    assign halted_o = err_q || stall_q || nakto_q;
    assign tog_o    = tog_q;

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

    // R2
    ack_clears_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_i.ack && !set_rdy) |=> !rdy_q);

    // R6
    err_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> irq_o);

endmodule

// File: rtl/usb_host_out_seq.sv
module usb_host_out_seq
    import usb_out_pkg::*;
#(
    parameter int RESP_CYCLES = 16,
    parameter int MISS_LIMIT  = 3,
    parameter int PKT_SLOTS   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_wr,
    input  logic [11:0] csr_wdata,
    output logic [11:0] csr_rdata,
    input  logic [1:0]  cfg_proto,
    input  logic [7:0]  cfg_interval,
    input  logic        fifo_load,
    input  logic        sof,
    output logic        tok_req,
    output logic        tok_data1,
    input  logic        hs_valid,
    input  logic [1:0]  hs_code,
    output logic        irq
);
    seq_ev_t ev;
    logic rdy, halted, tog, busy, fc_clr, limit_hit, is_intr;

    assign is_intr = (cfg_proto == PROTO_INTR);

    usb_out_csr #(.PKT_SLOTS(PKT_SLOTS)) csr_i (
        .clk(clk), .rst(rst), .wr_i(csr_wr), .wdata_i(csr_wdata),
        .fifo_load_i(fifo_load), .ev_i(ev), .rdata_o(csr_rdata),
        .rdy_o(rdy), .halted_o(halted), .tog_o(tog), .irq_o(irq)
    );

    usb_out_budget budget_i (
        .clk(clk), .rst(rst), .sof_i(sof), .active_i(busy),
        .clr_i(fc_clr), .interval_i(cfg_interval), .limit_hit_o(limit_hit)
    );

    usb_out_seq #(.RESP_CYCLES(RESP_CYCLES), .MISS_LIMIT(MISS_LIMIT)) seq_i (
        .clk(clk), .rst(rst), .go_i(rdy && !halted), .is_intr_i(is_intr),
        .sof_i(sof), .hs_valid_i(hs_valid), .hs_code_i(hs_code),
        .limit_hit_i(limit_hit), .tok_req_o(tok_req), .busy_o(busy),
        .fc_clr_o(fc_clr), .ev_o(ev)
    );

    assign tok_data1 = tog;

    // R3
    halt_blocks_tok_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !tok_req);

endmodule

// File: tb/usb_host_out_seq_tb_top.sv
`timescale 1ns/1ps
module usb_host_out_seq_tb_top;
    localparam int RESP = 6;
    localparam int SLOTS = 2;
    localparam int MISSES = 3;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csr_wr = 1'b0;
    logic [11:0] csr_wdata = '0;
    logic [11:0] csr_rdata;
    logic [1:0] cfg_proto = 2'b10;
    logic [7:0] cfg_interval = 8'd0;
    logic fifo_load = 1'b0;
    logic sof = 1'b0;
    logic tok_req, tok_data1, irq;
    logic hs_valid = 1'b0;
    logic [1:0] hs_code = 2'd0;

    always #4 clk = ~clk;

    usb_host_out_seq #(.RESP_CYCLES(RESP), .MISS_LIMIT(MISSES), .PKT_SLOTS(SLOTS)) dut_i (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .cfg_proto(cfg_proto), .cfg_interval(cfg_interval),
        .fifo_load(fifo_load), .sof(sof), .tok_req(tok_req), .tok_data1(tok_data1),
        .hs_valid(hs_valid), .hs_code(hs_code), .irq(irq)
    );

    int n_chk = 0, n_fail = 0, cycles = 0;
    int tok_cnt = 0, irq_cnt = 0, sof_cnt = 0;
    string cur_req = "R12";

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph = 0, m_tmr = 0, m_miss = 0, m_fc = 0, m_cnt = 0;
    bit m_rdy, m_err, m_stall, m_nto, m_tog, m_force, m_irq;

    function automatic int lim_of(input int m);
        int e;
        e = (m > 16) ? 15 : m - 1;
        return 1 << e;
    endfunction

    always @(posedge clk) begin
        bit ack, stl, nto, er, done, clr, wr0, fl, intr;
        int nph;
        if (rst) begin
            m_ph = 0; m_tmr = 0; m_miss = 0; m_fc = 0; m_cnt = 0;
            m_rdy = 0; m_err = 0; m_stall = 0; m_nto = 0;
            m_tog = 0; m_force = 0; m_irq = 0;
        end else begin
            ack = 0; stl = 0; nto = 0; er = 0; done = 0; clr = 0;
            intr = (cfg_proto == 2'b11);
            nph = m_ph;
            if (m_ph == 0) begin
                if (m_rdy && !m_err && !m_stall && !m_nto) begin
                    nph = 1; clr = 1; m_miss = 0;
                end
            end else if (m_ph == 1) begin
                nph = 2; m_tmr = 0;
            end else if (m_ph == 2) begin
                if (hs_valid && hs_code != 2'd3) begin
                    done = 1; m_miss = 0;
                    if (hs_code == 2'd0) begin ack = 1; clr = 1; nph = 0; end
                    else if (hs_code == 2'd2) begin stl = 1; nph = 0; end
                    else if (!intr && cfg_interval >= 2 && m_fc >= lim_of(cfg_interval)) begin
                        nto = 1; nph = 0;
                    end else nph = intr ? 3 : 1;
                end else if (m_tmr == RESP - 1) begin
                    done = 1;
                    if (m_miss == MISSES - 1) begin er = 1; nph = 0; end
                    else begin m_miss++; nph = 1; end
                end else m_tmr++;
            end else begin
                if (sof) nph = 1;
            end
            if (clr) m_fc = 0;
            else if (sof && m_ph != 0 && m_fc < 65535) m_fc++;
            wr0 = csr_wr && csr_wdata[0];
            fl = csr_wr && csr_wdata[3];
            if (csr_wr && csr_wdata[6]) m_tog = 0;
            else if (csr_wr && csr_wdata[9]) m_tog = csr_wdata[8];
            else if (m_force ? done : ack) m_tog = !m_tog;
            if (csr_wr) m_force = csr_wdata[11];
            m_rdy = (m_rdy && !ack && !fl) || wr0;
            m_err = (m_err && !(csr_wr && !csr_wdata[2])) || er;
            m_stall = (m_stall && !(csr_wr && !csr_wdata[5])) || stl;
            m_nto = (m_nto && !(csr_wr && !csr_wdata[7])) || nto;
            if (fifo_load && !(ack || fl) && m_cnt < SLOTS) m_cnt++;
            else if ((ack || fl) && !fifo_load && m_cnt > 0) m_cnt--;
            m_irq = ack || stl || er || nto;
            m_ph = nph;
        end
    end

    function automatic int m_word();
        int w;
        w = 0;
        w |= int'(m_rdy);
        w |= int'(m_cnt != 0) << 1;
        w |= int'(m_err) << 2;
        w |= int'(m_stall) << 5;
        w |= int'(m_nto) << 7;
        w |= int'(m_tog) << 8;
        w |= int'(m_force) << 11;
        return w;
    endfunction

    // compare every cycle, count events, watchdog
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk({cur_req, " tok_req"}, int'(tok_req), int'(m_ph == 1));
            chk({cur_req, " tok_data1"}, int'(tok_data1), int'(m_tog));
            chk({cur_req, " csr"}, int'(csr_rdata), m_word());
            chk({cur_req, " irq"}, int'(irq), int'(m_irq));
            if (tok_req) tok_cnt++;
            if (irq) irq_cnt++;
        end
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // handshake responder: 0 ACK, 1 NAK, 2 STALL, 3 silence
    int plan[$];
    int dflt = 0, cd = 0, cur_resp = 0;
    always @(negedge clk) begin
        hs_valid = 1'b0;
        if (cd > 0) begin
            cd--;
            if (cd == 0 && cur_resp != 3) begin
                hs_valid = 1'b1;
                hs_code = 2'(cur_resp);
            end
        end
        if (!rst && tok_req) begin
            cur_resp = (plan.size() > 0) ? plan.pop_front() : dflt;
            cd = LAT;
        end
    end

    // SOF generator
    bit sof_en = 0;
    int sof_ph = 0;
    always @(negedge clk) begin
        sof = 1'b0;
        if (sof_en) begin
            sof_ph++;
            if (sof_ph == 10) begin sof = 1'b1; sof_ph = 0; sof_cnt++; end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic load();
        @(negedge clk);
        fifo_load = 1'b1;
        @(negedge clk);
        fifo_load = 1'b0;
    endtask

    task automatic wait_irq(input int maxc);
        int s;
        s = irq_cnt;
        for (int i = 0; i < maxc && irq_cnt == s; i++) @(negedge clk);
        cyc(2);
    endtask

    initial begin
        int t0, s0;
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R12 reset state
        chk("R12 reset csr", int'(csr_rdata), 0);
        chk("R12 reset tok_req", int'(tok_req), 0);
        chk("R12 reset irq", int'(irq), 0);

        // R9 FIFO count saturates at two, flush removes one each
        cur_req = "R9";
        load(); load(); load();
        chk("R9 not-empty", int'(csr_rdata[1]), 1);
        wr(12'h008);
        chk("R9 one left", int'(csr_rdata[1]), 1);
        wr(12'h008);
        chk("R9 empty after two flushes", int'(csr_rdata[1]), 0);

        // R1/R2 single ACK
        cur_req = "R2";
        load();
        t0 = tok_cnt; s0 = irq_cnt;
        plan.push_back(0);
        wr(12'h001);
        wait_irq(100);
        chk("R1 one token", tok_cnt - t0, 1);
        chk("R2 rdy cleared", int'(csr_rdata[0]), 0);
        chk("R2 toggle flipped", int'(csr_rdata[8]), 1);
        chk("R2 fifo drained", int'(csr_rdata[1]), 0);
        chk("R2 irq pulses", irq_cnt - s0, 1);

        // R4 NAK retries without budget
        cur_req = "R4";
        load();
        t0 = tok_cnt;
        plan.push_back(1); plan.push_back(1); plan.push_back(0);
        wr(12'h001);
        wait_irq(200);
        chk("R4 retried after NAKs", tok_cnt - t0, 3);
        chk("R4 toggle back to 0", int'(csr_rdata[8]), 0);

        // R3 STALL halts; R8 write 1 keeps, write 0 clears and resumes
        cur_req = "R3";
        load();
        plan.push_back(2);
        wr(12'h001);
        wait_irq(100);
        chk("R3 stall bit", int'(csr_rdata[5]), 1);
        t0 = tok_cnt;
        cyc(40);
        chk("R3 no token while stalled", tok_cnt - t0, 0);
        cur_req = "R8";
        wr(12'h020);
        cyc(10);
        chk("R8 stall kept by writing 1", int'(csr_rdata[5]), 1);
        plan.push_back(0);
        wr(12'h000);
        wait_irq(100);
        chk("R8 resumed after clear", tok_cnt - t0, 1);
        chk("R8 stall cleared", int'(csr_rdata[5]), 0);

        // R6 silence: three attempts then error; consecutive count resets
        cur_req = "R6";
        load();
        t0 = tok_cnt;
        plan.push_back(3); plan.push_back(3); plan.push_back(3);
        wr(12'h001);
        wait_irq(300);
        chk("R6 three attempts", tok_cnt - t0, 3);
        chk("R6 error bit", int'(csr_rdata[2]), 1);
        plan.push_back(3); plan.push_back(3); plan.push_back(1);
        plan.push_back(3); plan.push_back(3); plan.push_back(0);
        t0 = tok_cnt;
        wr(12'h000);
        wait_irq(400);
        chk("R6 NAK resets silent count", tok_cnt - t0, 6);
        chk("R6 no error after ACK", int'(csr_rdata[2]), 0);

        // R4 NAK timeout with interval 3 (four frames)
        cur_req = "R4";
        cfg_interval = 8'd3;
        dflt = 1;
        sof_en = 1;
        load();
        wr(12'h001);
        wait_irq(400);
        chk("R4 nak timeout bit", int'(csr_rdata[7]), 1);
        chk("R4 still ready", int'(csr_rdata[0]), 1);
        cur_req = "R8";
        t0 = tok_cnt;
        wr(12'h080);
        cyc(30);
        chk("R8 bit7 kept by writing 1", tok_cnt - t0, 0);
        wr(12'h000);
        wait_irq(400);
        chk("R8 resumed after clear", int'(tok_cnt > t0), 1);
        chk("R8 timed out again", int'(csr_rdata[7]), 1);
        wr(12'h088);
        wr(12'h000);
        t0 = tok_cnt;
        cyc(60);
        chk("R8 abort: no token", tok_cnt - t0, 0);
        chk("R8 abort: rdy clear", int'(csr_rdata[0]), 0);

        // R5 interval 0: unlimited NAK retries
        cur_req = "R5";
        cfg_interval = 8'd0;
        load();
        s0 = irq_cnt;
        wr(12'h001);
        cyc(200);
        chk("R5 no timeout", int'(csr_rdata[7]), 0);
        chk("R5 no irq", irq_cnt - s0, 0);
        dflt = 0;
        wait_irq(100);
        chk("R5 completes", int'(csr_rdata[0]), 0);

        // R7 interrupt endpoint: one retry per frame, no timeout
        cur_req = "R7";
        cfg_proto = 2'b11;
        cfg_interval = 8'd2;
        dflt = 1;
        load();
        t0 = tok_cnt; s0 = sof_cnt;
        wr(12'h001);
        cyc(120);
        chk("R7 tokens bounded by frames", int'((tok_cnt - t0) <= (sof_cnt - s0) + 1), 1);
        chk("R7 retried", int'((tok_cnt - t0) >= 5), 1);
        chk("R7 no timeout", int'(csr_rdata[7]), 0);
        dflt = 0;
        wait_irq(100);
        chk("R7 completes", int'(csr_rdata[0]), 0);
        cfg_proto = 2'b10;
        sof_en = 0;

        // R10 toggle clear / load
        cur_req = "R10";
        wr(12'h300);
        chk("R10 toggle loaded 1", int'(csr_rdata[8]), 1);
        wr(12'h040);
        chk("R10 toggle cleared", int'(csr_rdata[8]), 0);
        wr(12'h340);
        chk("R10 clear beats load", int'(csr_rdata[8]), 0);

        // R11 forced toggle: NAK, NAK, ACK flips three times
        cur_req = "R11";
        load();
        plan.push_back(1); plan.push_back(1); plan.push_back(0);
        wr(12'h801);
        wait_irq(200);
        chk("R11 force bit", int'(csr_rdata[11]), 1);
        chk("R11 toggle after three attempts", int'(csr_rdata[8]), 1);

        cyc(5);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule